// File: doc/BRIEF.md
# Receive MSDU Descriptor Stream Merger

This block takes a stream of 32-bit receive buffer descriptors, one per accepted handshake. An MSDU that did not fit in one buffer arrives as a chain of descriptors, and the block folds each chain into a single summary record. The length comes from the chain's opening buffer. Every other field comes from the closing buffer, which is the one whose continuation bit is clear.

The block also follows MPDU boundaries. It counts the records in each MPDU and flags an MPDU that holds only one MSDU. It counts the MSDUs it discards because they carry the drop mark. It keeps two sticky error flags: one for an illegal combination of boundary flag and continuation bit, and one for an out-of-order MSDU sequence. The input never stalls, because `descReady` is held high. Every output is registered, so a record appears in the cycle after its closing descriptor is accepted.

Top module: `rxMsduMerger`

## Requirements
- R1: A descriptor with continuation (bit 2) set produces no record. A descriptor with continuation clear completes the MSDU, and `recValid` pulses for one cycle in the next cycle, unless the MSDU is dropped (R5).
- R2: `recLength` is the length field (bits 16:3) of the first buffer of the chain. Length fields in later buffers have no effect. For a single-buffer MSDU it is the length of that buffer.
- R3: These fields are all taken from the closing buffer: first (bit 0), last (bit 1), SA-valid (bit 18), DA-valid (bit 19), IP checksum fail (bit 23), TCP/UDP checksum fail (bit 22), from-DS (bit 24), to-DS (bit 25), intra-BSS (bit 26), chip ID (bits 28:27), decap format (bits 30:29: 0 raw, 1 native WiFi, 2 Ethernet II/SNAP, 3 802.3) and link ID (bit 31).
- R4: `recMcast` equals bit 20 when DA-valid (bit 19) is set, and 0 otherwise. `recPadBytes` is bit 21 times two (0 or 2).
- R5: A completing MSDU whose closing buffer has drop (bit 17) set gives no record. It increments `dropCount`, which saturates at all ones.
- R6: `recSingle` pulses together with `recValid` when the record has both first and last set.
- R7: When an MSDU with last set completes, `mpduDone` pulses and `mpduMsduCount` shows the number of non-dropped MSDUs in that MPDU. An MSDU marked first restarts the count.
- R8: `recBufCount` is the number of buffers in the chain, saturating at 15.
- R9: Any accepted descriptor with both last (bit 1) and continuation (bit 2) set raises `errContLast`, which stays set until reset.
- R10: `errSeq` is raised and stays set until reset in two cases: a completing MSDU without first arrives while no MPDU is open, or one with first arrives while an MPDU is open. An MPDU opens on any completion without last and closes on any completion with last.
- R11: After reset `recValid`, `recSingle`, `mpduDone`, both error flags and `dropCount` are 0, and `descReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descValid | input | 1 | Descriptor word valid |
| descWord | input | 32 | Descriptor word |
| descReady | output | 1 | Accepting descriptors (always 1) |
| recValid | output | 1 | Merged record valid |
| recLength | output | 14 | MSDU length in bytes |
| recFirst | output | 1 | First MSDU of MPDU |
| recLast | output | 1 | Last MSDU of MPDU |
| recSaValid | output | 1 | Source address found |
| recDaValid | output | 1 | Destination address found |
| recMcast | output | 1 | Destination multicast/broadcast, gated |
| recPadBytes | output | 2 | L3 header padding in bytes |
| recL4Fail | output | 1 | TCP/UDP checksum failed |
| recIpFail | output | 1 | IP checksum failed |
| recFromDs | output | 1 | From-DS bit |
| recToDs | output | 1 | To-DS bit |
| recIntraBss | output | 1 | Needs intra-BSS routing |
| recChipId | output | 2 | Destination chip |
| recDecap | output | 2 | Decap format |
| recLinkId | output | 1 | Destination link |
| recBufCount | output | 4 | Buffers in MSDU, saturating |
| recSingle | output | 1 | MPDU holds this MSDU only |
| mpduDone | output | 1 | MPDU closed this cycle |
| mpduMsduCount | output | 8 | Records in the closed MPDU |
| dropCount | output | 16 | Dropped MSDUs, saturating |
| errContLast | output | 1 | Sticky last-with-continuation error |
| errSeq | output | 1 | Sticky MPDU sequence error |

## Verification
The bench gives each buffer of a chain a different length. A design that captured the length from the wrong buffer would then report the last or middle buffer's length. A chain of seventeen buffers checks that the buffer count saturates instead of wrapping to a small value. A dropped MSDU that closes an MPDU checks two things: no record may leak out, and the MPDU count must exclude the dropped MSDU while the MPDU still closes. Multicast with DA-valid clear, flags set only on the closing buffer, and randomly placed sequence and continuation-with-last violations expose flags that are ungated, taken from the first buffer, or not sticky.

// File: rtl/rxmm_pkg.sv
package rxmm_pkg;

  localparam int LEN_W = 14;

  // descriptor word, bit 31 down to bit 0
  typedef struct packed {
    logic             linkId;
    logic [1:0]       decap;
    logic [1:0]       chipId;
    logic             intraBss;
    logic             toDs;
    logic             fromDs;
    logic             ipFail;
    logic             l4Fail;
    logic             padMsb;
    logic             mcast;
    logic             daValid;
    logic             saValid;
    logic             drop;
    logic [LEN_W-1:0] length;
    logic             cont;
    logic             last;
    logic             first;
  } rxDesc_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;    // opening buffer of a multi-buffer chain
    logic extend;     // further continuation buffer
    logic finish;     // closing buffer accepted
    logic emit;       // finish and not dropped
    logic dropHit;    // finish and dropped
    logic close;      // finish with last flag
    logic fresh;      // closing buffer carries first flag
    logic useStored;  // a chain was open before this buffer
  } rxStrobe_t;

endpackage

// File: rtl/rxmm_ctrl.sv
module rxmm_ctrl
  import rxmm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      descValid,
  input  logic      descCont,
  input  logic      descFirst,
  input  logic      descLast,
  input  logic      descDrop,
  output logic      descReady,
  output rxStrobe_t stb,
  output logic      errContLast,
  output logic      errSeq
);
  logic inChain;
  logic mpduOpen;
  logic take;
  logic seqBad;

  assign descReady = 1'b1;
  assign take      = descValid & descReady;

  always_comb begin
    stb           = '0;
    stb.capture   = take & descCont & ~inChain;
    stb.extend    = take & descCont & inChain;
    stb.finish    = take & ~descCont;
    stb.emit      = stb.finish & ~descDrop;
    stb.dropHit   = stb.finish & descDrop;
    stb.close     = stb.finish & descLast;
    stb.fresh     = descFirst;
    stb.useStored = inChain;
  end

  // first while open, or not-first while closed
  assign seqBad = stb.finish & (descFirst == mpduOpen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inChain     <= 1'b0;
      mpduOpen    <= 1'b0;
      errContLast <= 1'b0;
      errSeq      <= 1'b0;
    end else begin
      if (take) inChain <= descCont;
      if (stb.finish) mpduOpen <= ~descLast;
      if (take & descCont & descLast) errContLast <= 1'b1;
      if (seqBad) errSeq <= 1'b1;
    end
  end
endmodule

// File: rtl/rxmm_datapath.sv
module rxmm_datapath
  import rxmm_pkg::*;
#(
  parameter int BUF_MAX = 15,
  parameter int COUNT_W = 8,
  parameter int DROP_W  = 16,
  localparam int BUF_W  = $clog2(BUF_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxStrobe_t          stb,
  input  rxDesc_t            desc,
  output logic               recValid,
  output logic [LEN_W-1:0]   recLength,
  output logic               recFirst,
  output logic               recLast,
  output logic               recSaValid,
  output logic               recDaValid,
  output logic               recMcast,
  output logic [1:0]         recPadBytes,
  output logic               recL4Fail,
  output logic               recIpFail,
  output logic               recFromDs,
  output logic               recToDs,
  output logic               recIntraBss,
  output logic [1:0]         recChipId,
  output logic [1:0]         recDecap,
  output logic               recLinkId,
  output logic [BUF_W-1:0]   recBufCount,
  output logic               recSingle,
  output logic               mpduDone,
  output logic [COUNT_W-1:0] mpduMsduCount,
  output logic [DROP_W-1:0]  dropCount
);
  localparam logic [BUF_W-1:0] BUF_CAP = BUF_W'(BUF_MAX);

  logic [LEN_W-1:0]   lenHold;
  logic [BUF_W-1:0]   bufHold;
  logic [BUF_W-1:0]   bufNext;
  logic [BUF_W-1:0]   bufTotal;
  logic [COUNT_W-1:0] msduCnt;
  logic [COUNT_W-1:0] cntBase;
  logic [COUNT_W-1:0] cntNext;

  assign bufNext  = (bufHold == BUF_CAP) ? BUF_CAP : bufHold + 1'b1;
  assign bufTotal = stb.useStored ? bufNext : BUF_W'(1);
  assign cntBase  = stb.fresh ? '0 : msduCnt;
  assign cntNext  = cntBase + {{(COUNT_W-1){1'b0}}, stb.emit};

  // chain state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenHold <= '0;
      bufHold <= '0;
    end else if (stb.capture) begin
      lenHold <= desc.length;
      bufHold <= BUF_W'(1);
    end else if (stb.extend) begin
      bufHold <= bufNext;
    end else if (stb.finish) begin
      bufHold <= '0;
    end
  end

  // record register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      recValid    <= 1'b0;
      recSingle   <= 1'b0;
      recLength   <= '0;
      recFirst    <= 1'b0;
      recLast     <= 1'b0;
      recSaValid  <= 1'b0;
      recDaValid  <= 1'b0;
      recMcast    <= 1'b0;
      recPadBytes <= '0;
      recL4Fail   <= 1'b0;
      recIpFail   <= 1'b0;
      recFromDs   <= 1'b0;
      recToDs     <= 1'b0;
      recIntraBss <= 1'b0;
      recChipId   <= '0;
      recDecap    <= '0;
      recLinkId   <= 1'b0;
      recBufCount <= '0;
    end else begin
      recValid  <= stb.emit;
      recSingle <= stb.emit & desc.first & desc.last;
      if (stb.emit) begin
        recLength   <= stb.useStored ? lenHold : desc.length;
        recFirst    <= desc.first;
        recLast     <= desc.last;
        recSaValid  <= desc.saValid;
        recDaValid  <= desc.daValid;
        recMcast    <= desc.mcast & desc.daValid;
        recPadBytes <= {desc.padMsb, 1'b0};
        recL4Fail   <= desc.l4Fail;
        recIpFail   <= desc.ipFail;
        recFromDs   <= desc.fromDs;
        recToDs     <= desc.toDs;
        recIntraBss <= desc.intraBss;
        recChipId   <= desc.chipId;
        recDecap    <= desc.decap;
        recLinkId   <= desc.linkId;
        recBufCount <= bufTotal;
      end
    end
  end

  // MPDU and drop accounting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msduCnt       <= '0;
      mpduDone      <= 1'b0;
      mpduMsduCount <= '0;
      dropCount     <= '0;
    end else begin
      mpduDone <= stb.close;
      if (stb.close) begin
        mpduMsduCount <= cntNext;
        msduCnt       <= '0;
      end else if (stb.finish) begin
        msduCnt <= cntNext;
      end
      if (stb.dropHit && dropCount != {DROP_W{1'b1}}) dropCount <= dropCount + 1'b1;
    end
  end
endmodule

// File: rtl/rxMsduMerger.sv
module rxMsduMerger
  import rxmm_pkg::*;
#(
  parameter int BUF_MAX = 15,
  parameter int COUNT_W = 8,
  parameter int DROP_W  = 16,
  localparam int BUF_W  = $clog2(BUF_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               descValid,
  input  logic [31:0]        descWord,
  output logic               descReady,
  output logic               recValid,
  output logic [13:0]        recLength,
  output logic               recFirst,
  output logic               recLast,
  output logic               recSaValid,
  output logic               recDaValid,
  output logic               recMcast,
  output logic [1:0]         recPadBytes,
  output logic               recL4Fail,
  output logic               recIpFail,
  output logic               recFromDs,
  output logic               recToDs,
  output logic               recIntraBss,
  output logic [1:0]         recChipId,
  output logic [1:0]         recDecap,
  output logic               recLinkId,
  output logic [BUF_W-1:0]   recBufCount,
  output logic               recSingle,
  output logic               mpduDone,
  output logic [COUNT_W-1:0] mpduMsduCount,
  output logic [DROP_W-1:0]  dropCount,
  output logic               errContLast,
  output logic               errSeq
);
  rxDesc_t   desc;
  rxStrobe_t stb;

  assign desc = rxDesc_t'(descWord);

  rxmm_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .descValid   (descValid),
    .descCont    (desc.cont),
    .descFirst   (desc.first),
    .descLast    (desc.last),
    .descDrop    (desc.drop),
    .descReady   (descReady),
    .stb         (stb),
    .errContLast (errContLast),
    .errSeq      (errSeq)
  );

  rxmm_datapath #(
    .BUF_MAX (BUF_MAX),
    .COUNT_W (COUNT_W),
    .DROP_W  (DROP_W)
  ) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .desc          (desc),
    .recValid      (recValid),
    .recLength     (recLength),
    .recFirst      (recFirst),
    .recLast       (recLast),
    .recSaValid    (recSaValid),
    .recDaValid    (recDaValid),
    .recMcast      (recMcast),
    .recPadBytes   (recPadBytes),
    .recL4Fail     (recL4Fail),
    .recIpFail     (recIpFail),
    .recFromDs     (recFromDs),
    .recToDs       (recToDs),
    .recIntraBss   (recIntraBss),
    .recChipId     (recChipId),
    .recDecap      (recDecap),
    .recLinkId     (recLinkId),
    .recBufCount   (recBufCount),
    .recSingle     (recSingle),
    .mpduDone      (mpduDone),
    .mpduMsduCount (mpduMsduCount),
    .dropCount     (dropCount)
  );
endmodule

// File: rtl/rxMsduMergerChk.sv
module rxMsduMergerChk #(
  parameter int BUF_W  = 4,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              descValid,
  input logic              descReady,
  input logic [31:0]       descWord,
  input logic              recValid,
  input logic              recFirst,
  input logic              recLast,
  input logic              recDaValid,
  input logic              recMcast,
  input logic [1:0]        recPadBytes,
  input logic [BUF_W-1:0]  recBufCount,
  input logic              recSingle,
  input logic [DROP_W-1:0] dropCount,
  input logic              errContLast,
  input logic              errSeq
);
  logic take;
  assign take = descValid & descReady;

  p_no_rec_on_cont_r1: assert property (@(posedge clk) disable iff (!rstN)
    take && descWord[2] |=> !recValid);

  p_mcast_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    recValid && !recDaValid |-> !recMcast);

  p_pad_even_r4: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> !recPadBytes[0]);

  p_drop_counts_r5: assert property (@(posedge clk) disable iff (!rstN)
    take && !descWord[2] && descWord[17] && (dropCount != {DROP_W{1'b1}})
      |=> !recValid && (dropCount == $past(dropCount) + 1'b1));

  p_single_with_rec_r6: assert property (@(posedge clk) disable iff (!rstN)
    recSingle |-> recValid && recFirst && recLast);

  p_bufcount_nonzero_r8: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> recBufCount != '0);

  p_contlast_raise_r9: assert property (@(posedge clk) disable iff (!rstN)
    take && descWord[2] && descWord[1] |=> errContLast);

  p_contlast_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errContLast |=> errContLast);

  p_seq_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    errSeq |=> errSeq);
endmodule

bind rxMsduMerger rxMsduMergerChk #(
  .BUF_W  (BUF_W),
  .DROP_W (DROP_W)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .descValid   (descValid),
  .descReady   (descReady),
  .descWord    (descWord),
  .recValid    (recValid),
  .recFirst    (recFirst),
  .recLast     (recLast),
  .recDaValid  (recDaValid),
  .recMcast    (recMcast),
  .recPadBytes (recPadBytes),
  .recBufCount (recBufCount),
  .recSingle   (recSingle),
  .dropCount   (dropCount),
  .errContLast (errContLast),
  .errSeq      (errSeq)
);

// File: tb/test_rxMsduMerger.sv
module test_rxMsduMerger;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        descValid = 1'b0;
  logic [31:0] descWord = '0;
  logic        descReady, recValid, recFirst, recLast, recSaValid, recDaValid, recMcast;
  logic [13:0] recLength;
  logic [1:0]  recPadBytes, recChipId, recDecap;
  logic        recL4Fail, recIpFail, recFromDs, recToDs, recIntraBss, recLinkId;
  logic [3:0]  recBufCount;
  logic        recSingle, mpduDone, errContLast, errSeq;
  logic [7:0]  mpduMsduCount;
  logic [15:0] dropCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxMsduMerger i_rxMsduMerger (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  bit        mChain, mOpen, mErrCL, mErrSeq;
  bit [13:0] mLen;
  int        mBuf, mCnt, mDrops;
  bit        eValid, eSingle, eDone;
  bit [34:0] eRec;
  bit [7:0]  eDoneCnt;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] mk(input bit [13:0] hi, input bit drop, input bit [13:0] len,
                                   input bit cont, input bit last, input bit first);
    return {hi, drop, len, cont, last, first};
  endfunction

  task automatic modelStep(input bit [31:0] w);
    bit [13:0] len;
    int bufs, base;
    eValid = 0; eSingle = 0; eDone = 0;
    if (w[1] && w[2]) mErrCL = 1;
    if (w[2]) begin
      if (!mChain) begin mLen = w[16:3]; mBuf = 1; end
      else if (mBuf < 15) mBuf++;
      mChain = 1;
    end else begin
      len  = mChain ? mLen : w[16:3];
      bufs = mChain ? ((mBuf < 15) ? mBuf + 1 : 15) : 1;
      if (w[0] == mOpen) mErrSeq = 1;
      base = w[0] ? 0 : mCnt;
      if (w[1]) begin eDone = 1; eDoneCnt = 8'((base + (w[17] ? 0 : 1)) & 255); mCnt = 0; end
      else mCnt = (base + (w[17] ? 0 : 1)) & 255;
      mOpen = !w[1];
      if (w[17]) begin
        if (mDrops < 65535) mDrops++;
      end else begin
        eValid  = 1;
        eSingle = w[0] & w[1];
        eRec = {len, w[0], w[1], w[18], w[19], w[20] & w[19], w[21], 1'b0,
                w[22], w[23], w[24], w[25], w[26], w[28:27], w[30:29], w[31], 4'(bufs)};
      end
      mChain = 0;
    end
  endtask

  task automatic send(input bit [31:0] w);
    @(negedge clk);
    descValid = 1'b1;
    descWord  = w;
    modelStep(w);
    @(negedge clk);
    descValid = 1'b0;
    check("R1 recValid", recValid, eValid);
    if (eValid)
      check("R2/R3/R4/R8 record",
            {recLength, recFirst, recLast, recSaValid, recDaValid, recMcast, recPadBytes,
             recL4Fail, recIpFail, recFromDs, recToDs, recIntraBss, recChipId, recDecap,
             recLinkId, recBufCount}, eRec);
    check("R6 recSingle", recSingle, eSingle);
    check("R7 mpduDone", mpduDone, eDone);
    if (eDone) check("R7 mpduMsduCount", mpduMsduCount, eDoneCnt);
    check("R5 dropCount", dropCount, mDrops);
    check("R9 errContLast", errContLast, mErrCL);
    check("R10 errSeq", errSeq, mErrSeq);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset outputs",
          {recValid, recSingle, mpduDone, errContLast, errSeq, dropCount, descReady},
          {5'b0, 16'd0, 1'b1});
    rstN = 1'b1;

    // three-buffer chain, lengths differ, single-MSDU MPDU (R2, R6, R8)
    send(mk(14'h0000, 0, 14'd100, 1, 0, 0));
    send(mk(14'h0000, 0, 14'd7,   1, 0, 0));
    send(mk(14'h2A5B, 0, 14'd9,   0, 1, 1));
    // multicast without DA-valid, padding set (R4), MPDU of three (R7)
    send(mk(14'b0000_0000_0111_00, 0, 14'd60, 0, 0, 1));
    send(mk(14'b1110_0000_0011_00, 0, 14'd61, 0, 0, 0));
    send(mk(14'b0101_1011_1110_11, 0, 14'd62, 0, 1, 0));
    // dropped single-buffer MSDU closing an MPDU (R5, R7)
    send(mk(14'h0000, 0, 14'd30, 0, 0, 1));
    send(mk(14'h3FFF, 1, 14'd31, 0, 1, 0));
    // seventeen-buffer chain saturates buffer count (R8)
    for (int i = 0; i < 16; i++) send(mk(14'h0000, 0, 14'(200 + i), 1, 0, 0));
    send(mk(14'h0100, 0, 14'd5, 0, 1, 1));

    // random MSDUs with occasional protocol violations (R1..R10)
    for (int m = 0; m < 400; m++) begin
      int nb;
      bit [31:0] w;
      nb = ($urandom % 10 == 0) ? 15 + ($urandom % 4) : 1 + ($urandom % 4);
      for (int b = 0; b < nb - 1; b++) begin
        w = $urandom;
        w[2] = 1'b1;
        w[1] = ($urandom % 24 == 0);
        send(w);
      end
      w = $urandom;
      w[2]  = 1'b0;
      w[0]  = mOpen ? ($urandom % 10 == 0) : ($urandom % 10 != 0);
      w[1]  = ($urandom % 3 == 0);
      w[17] = ($urandom % 5 == 0);
      send(w);
      if ($urandom % 4 == 0) @(negedge clk);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule